// File: doc/BRIEF.md
# Cross-Clock Mailbox Register Pair

This block lets two ports on unrelated clocks pass single control words to each other outside the data queue. Port A (clock A) can post a word into the A-to-B slot, and port B (clock B) can post a word into the B-to-A slot. Each slot holds one word. The posting side sees an active-low full flag in its own clock domain. That flag goes low the moment a word is accepted. It comes back high only after the far side has read the word and that read has crossed back through a two-stage synchronizer. While the flag is low, further posts to that slot are dropped.

Each port has a mailbox-select input that chooses the target of its transfers. With select high, reads and writes go to the mailbox. With select low, the transfer belongs to the queue, which lives outside this block. The same select steers the port's output mux: it shows the incoming mailbox word or the queue output word that is supplied on an input. The port-B bus-size setting narrows both slots to 36, 18 or 9 bits. Bits above the active width are ignored on entry and driven as zero on exit. Mailbox traffic is never byte-reordered or serialized.

Neither port has back-pressure in the valid/ready sense. A post is a single-cycle strobe, and its acceptance is reported only through the full flag that the poster samples before posting. A read never stalls: it returns the stored word at once. All port pins are plain control and status signals.

Top module: `mbx_pair`

## Requirements
- R1: While reset is asserted and right after it, both full flags are high and both slots hold zero, so an enabled mailbox output reads zero.
- R2: A mailbox post (enable=1, write=1, select=1) whose full flag is high stores the word on that port's clock edge and drives the flag low from that edge on. Port A posts into the A-to-B slot; port B posts into the B-to-A slot.
- R3: A post while the slot's flag is low is ignored: the stored word and the flag are unchanged.
- R4: A post becomes visible to the reading port on the second reading-clock edge after the post edge. A mailbox read (enable=1, write=0, select=1) counts as a release only once the post is visible; earlier reads do not change the flag. After a counted read, the poster's flag returns high on the second poster-clock edge after the read edge.
- R5: The B-to-A slot follows R2 to R4 with the roles swapped: it is posted at clock B, read at clock A, and its flag is seen at port B.
- R6: A stored word stays readable after any number of reads and changes only on the next accepted post.
- R7: Bus size `b_bus_size` = 0 uses bits 35:0, 1 uses bits 17:0, and 2 or 3 uses bits 8:0. Inactive bits are stored as zero and read as zero on both ports.
- R8: With output enable low, a port's data output is zero. With output enable high, it shows the incoming mailbox word when select is high, and the queue word input unchanged when select is low.
- R9: Transfers with select low (queue transfers) change neither slot nor either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_a | input | 1 | Port A clock |
| a_en | input | 1 | Port A transfer enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbx | input | 1 | Port A mailbox select |
| a_wdata | input | 36 | Port A write word |
| a_oe | input | 1 | Port A output enable |
| a_fifo_q | input | 36 | Queue output word shown on port A when select is low |
| a_rdata | output | 36 | Port A read data |
| mail1_full_n | output | 1 | A-to-B slot full flag, low while a word is pending (clock A) |
| clk_b | input | 1 | Port B clock |
| b_en | input | 1 | Port B transfer enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_mbx | input | 1 | Port B mailbox select |
| b_wdata | input | 36 | Port B write word |
| b_oe | input | 1 | Port B output enable |
| b_fifo_q | input | 36 | Queue output word shown on port B when select is low |
| b_bus_size | input | 2 | Port B bus width setting, static during operation |
| b_rdata | output | 36 | Port B read data |
| mail2_full_n | output | 1 | B-to-A slot full flag, low while a word is pending (clock B) |

## Verification
Data outputs are combinational from stored state and are due the instant the post edge has passed. A flag drop is due at the post edge itself. A read becomes effective after the second far-clock edge following the post. A flag release is due at the second poster-clock edge after the counted read. The bench tracks these delays by counting edges of the other clock in a behavioural model. The two clocks are offset so that no A edge coincides with any B edge. Every output is compared against the model at the falling edge of its own clock, half a period after any change.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  // Port-B bus width selection; the two top codes both mean the 9-bit lane.
  typedef enum logic [1:0] {
    BUS_LONG  = 2'd0,
    BUS_WORD  = 2'd1,
    BUS_BYTE  = 2'd2,
    BUS_BYTE2 = 2'd3
  } bus_size_e;
endpackage

// File: rtl/mbx_sync.sv
`timescale 1ns/1ps
module mbx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_slot_wr.sv
`timescale 1ns/1ps
module mbx_slot_wr #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] wr_mask,
  input  logic              clr_tgl_far,
  output logic [DATA_W-1:0] mail_q,
  output logic              full_n,
  output logic              set_tgl
);
  logic clr_seen;

  // Release events from the reading domain arrive as a toggle.
  mbx_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (clr_tgl_far),
    .q    (clr_seen)
  );

  assign full_n = (set_tgl == clr_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_tgl <= 1'b0;
      mail_q  <= '0;
    end else if (wr_req && full_n) begin
      set_tgl <= ~set_tgl;
      mail_q  <= wr_data & wr_mask;
    end
  end

  AST_POST_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full_n) |=> !full_n) else $error("post did not drop flag"); // R2

  AST_BLOCKED_POST_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !full_n) |=> $stable(mail_q)) else $error("blocked post changed word"); // R3
endmodule

// File: rtl/mbx_slot_rd.sv
`timescale 1ns/1ps
module mbx_slot_rd #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  input  logic set_tgl_far,
  output logic clr_tgl,
  output logic pending
);
  logic set_seen;

  // Post events from the writing domain arrive as a toggle.
  mbx_sync #(.STAGES(SYNC_STAGES)) u_set_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (set_tgl_far),
    .q    (set_seen)
  );

  assign pending = (set_seen != clr_tgl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                clr_tgl <= 1'b0;
    else if (rd_req && pending) clr_tgl <= ~clr_tgl;
  end

  AST_RELEASE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(clr_tgl)) |-> $past(pending)) else $error("release without pending word"); // R4

  AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !rd_req) |=> pending) else $error("pending dropped without read"); // R6
endmodule

// File: rtl/mbx_pair.sv
`timescale 1ns/1ps
module mbx_pair #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rst_n,
  input  logic              clk_a,
  input  logic              a_en,
  input  logic              a_wr,
  input  logic              a_mbx,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic              a_oe,
  input  logic [DATA_W-1:0] a_fifo_q,
  output logic [DATA_W-1:0] a_rdata,
  output logic              mail1_full_n,
  input  logic              clk_b,
  input  logic              b_en,
  input  logic              b_wr,
  input  logic              b_mbx,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic              b_oe,
  input  logic [DATA_W-1:0] b_fifo_q,
  input  logic [1:0]        b_bus_size,
  output logic [DATA_W-1:0] b_rdata,
  output logic              mail2_full_n
);
  import mbx_pkg::*;

  localparam int WORD_W = DATA_W / 2;
  localparam int BYTE_W = DATA_W / 4;
  localparam logic [DATA_W-1:0] MASK_LONG = '1;
  localparam logic [DATA_W-1:0] MASK_WORD = {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_BYTE = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  logic [DATA_W-1:0] lane_mask;
  always_comb begin
    case (bus_size_e'(b_bus_size))
      BUS_LONG: lane_mask = MASK_LONG;
      BUS_WORD: lane_mask = MASK_WORD;
      default:  lane_mask = MASK_BYTE;
    endcase
  end

  logic a_post, a_take, b_post, b_take;
  assign a_post = a_en &  a_wr & a_mbx;
  assign a_take = a_en & ~a_wr & a_mbx;
  assign b_post = b_en &  b_wr & b_mbx;
  assign b_take = b_en & ~b_wr & b_mbx;

  logic [DATA_W-1:0] mail1_q, mail2_q;
  logic set1_tgl, clr1_tgl, set2_tgl, clr2_tgl;
  logic pend1_b, pend2_a;

  // A-to-B slot: posted at clock A, taken at clock B.
  mbx_slot_wr #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_m1_wr (
    .clk(clk_a), .rst_n(rst_n), .wr_req(a_post), .wr_data(a_wdata),
    .wr_mask(lane_mask), .clr_tgl_far(clr1_tgl), .mail_q(mail1_q),
    .full_n(mail1_full_n), .set_tgl(set1_tgl)
  );
  mbx_slot_rd #(.SYNC_STAGES(SYNC_STAGES)) u_m1_rd (
    .clk(clk_b), .rst_n(rst_n), .rd_req(b_take), .set_tgl_far(set1_tgl),
    .clr_tgl(clr1_tgl), .pending(pend1_b)
  );

  // B-to-A slot: posted at clock B, taken at clock A.
  mbx_slot_wr #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_m2_wr (
    .clk(clk_b), .rst_n(rst_n), .wr_req(b_post), .wr_data(b_wdata),
    .wr_mask(lane_mask), .clr_tgl_far(clr2_tgl), .mail_q(mail2_q),
    .full_n(mail2_full_n), .set_tgl(set2_tgl)
  );
  mbx_slot_rd #(.SYNC_STAGES(SYNC_STAGES)) u_m2_rd (
    .clk(clk_a), .rst_n(rst_n), .rd_req(a_take), .set_tgl_far(set2_tgl),
    .clr_tgl(clr2_tgl), .pending(pend2_a)
  );

  // Output steering: mailbox word (lane-masked) or queue word.
  always_comb begin
    if (!a_oe)      a_rdata = '0;
    else if (a_mbx) a_rdata = mail2_q & lane_mask;
    else            a_rdata = a_fifo_q;
  end

  always_comb begin
    if (!b_oe)      b_rdata = '0;
    else if (b_mbx) b_rdata = mail1_q & lane_mask;
    else            b_rdata = b_fifo_q;
  end

  AST_QUEUE_POST_NO_FLAG_A: assert property (@(posedge clk_a) disable iff (!rst_n)
    (a_en && !a_mbx && mail1_full_n && !pend1_b) |=> mail1_full_n) else $error("queue transfer touched slot 1"); // R9
endmodule

// File: tb/mbx_pair_tb.sv
`timescale 1ns/1ps
module mbx_pair_tb_top;
  localparam real CLK_A_PERIOD = 10.0;
  localparam real CLK_B_PERIOD = 14.0;

  logic rst_n = 1'b0;
  logic clk_a = 1'b0, clk_b = 1'b0;
  logic a_en = 0, a_wr = 0, a_mbx = 1, a_oe = 1;
  logic b_en = 0, b_wr = 0, b_mbx = 1, b_oe = 1;
  logic [35:0] a_wdata = '0, a_fifo_q = '0, b_wdata = '0, b_fifo_q = '0;
  logic [1:0]  b_bus_size = 2'd0;
  logic [35:0] a_rdata, b_rdata;
  logic mail1_full_n, mail2_full_n;

  mbx_pair dut_i (
    .rst_n(rst_n), .clk_a(clk_a), .a_en(a_en), .a_wr(a_wr), .a_mbx(a_mbx),
    .a_wdata(a_wdata), .a_oe(a_oe), .a_fifo_q(a_fifo_q), .a_rdata(a_rdata),
    .mail1_full_n(mail1_full_n), .clk_b(clk_b), .b_en(b_en), .b_wr(b_wr),
    .b_mbx(b_mbx), .b_wdata(b_wdata), .b_oe(b_oe), .b_fifo_q(b_fifo_q),
    .b_bus_size(b_bus_size), .b_rdata(b_rdata), .mail2_full_n(mail2_full_n)
  );

  initial forever #(CLK_A_PERIOD/2.0) clk_a = ~clk_a;
  initial begin
    #1.3;
    forever begin
      clk_b = 1'b1; #(CLK_B_PERIOD/2.0);
      clk_b = 1'b0; #(CLK_B_PERIOD/2.0);
    end
  end

  int n_run = 0, n_fail = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input string what, input logic [35:0] act, input logic [35:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [35:0] lane(input logic [1:0] s);
    case (s)
      2'd0:    return 36'hF_FFFF_FFFF;
      2'd1:    return 36'h0_0003_FFFF;
      default: return 36'h0_0000_01FF;
    endcase
  endfunction

  // Behavioural reference: slot words, flags as each side sees them,
  // and edge counters for events crossing to the other clock.
  logic [35:0] m_mail1 = '0, m_mail2 = '0;
  bit m_full1 = 0, m_pend1 = 0, m_full2 = 0, m_pend2 = 0;
  bit s1_go = 0, c1_go = 0, s2_go = 0, c2_go = 0;
  int s1_n = 0, c1_n = 0, s2_n = 0, c2_n = 0;

  task automatic model_reset();
    m_mail1 = '0; m_mail2 = '0;
    m_full1 = 0; m_pend1 = 0; m_full2 = 0; m_pend2 = 0;
    s1_go = 0; c1_go = 0; s2_go = 0; c2_go = 0;
  endtask

  always @(posedge clk_a) begin
    if (!rst_n) model_reset();
    else begin
      if (a_en && a_wr && a_mbx && !m_full1) begin
        m_mail1 = a_wdata & lane(b_bus_size); m_full1 = 1; s1_go = 1; s1_n = 0;
      end
      if (a_en && !a_wr && a_mbx && m_pend2) begin
        m_pend2 = 0; c2_go = 1; c2_n = 0;
      end
      if (s2_go) begin s2_n++; if (s2_n == 2) begin m_pend2 = 1; s2_go = 0; end end
      if (c1_go) begin c1_n++; if (c1_n == 2) begin m_full1 = 0; c1_go = 0; end end
    end
  end

  always @(posedge clk_b) begin
    if (!rst_n) model_reset();
    else begin
      if (b_en && b_wr && b_mbx && !m_full2) begin
        m_mail2 = b_wdata & lane(b_bus_size); m_full2 = 1; s2_go = 1; s2_n = 0;
      end
      if (b_en && !b_wr && b_mbx && m_pend1) begin
        m_pend1 = 0; c1_go = 1; c1_n = 0;
      end
      if (s1_go) begin s1_n++; if (s1_n == 2) begin m_pend1 = 1; s1_go = 0; end end
      if (c2_go) begin c2_n++; if (c2_n == 2) begin m_full2 = 0; c2_go = 0; end end
    end
  end

  // Per-clock comparison, half a period after each port's active edge.
  always @(negedge clk_a) if (rst_n) begin
    chk(cur_req, "mail1_full_n", {35'b0, mail1_full_n}, {35'b0, !m_full1});
    chk(cur_req, "a_rdata", a_rdata,
        !a_oe ? 36'b0 : (a_mbx ? (m_mail2 & lane(b_bus_size)) : a_fifo_q));
  end

  always @(negedge clk_b) if (rst_n) begin
    chk(cur_req, "mail2_full_n", {35'b0, mail2_full_n}, {35'b0, !m_full2});
    chk(cur_req, "b_rdata", b_rdata,
        !b_oe ? 36'b0 : (b_mbx ? (m_mail1 & lane(b_bus_size)) : b_fifo_q));
  end

  task automatic a_drive(input bit en, input bit wr, input bit mbx, input bit oe,
                         input logic [35:0] d, input logic [35:0] fq);
    @(posedge clk_a); #1;
    a_en = en; a_wr = wr; a_mbx = mbx; a_oe = oe; a_wdata = d; a_fifo_q = fq;
  endtask

  task automatic b_drive(input bit en, input bit wr, input bit mbx, input bit oe,
                         input logic [35:0] d, input logic [35:0] fq);
    @(posedge clk_b); #1;
    b_en = en; b_wr = wr; b_mbx = mbx; b_oe = oe; b_wdata = d; b_fifo_q = fq;
  endtask

  task automatic a_idle(input int n);
    for (int i = 0; i < n; i++) a_drive(0, 0, 1, 1, 36'h0, 36'h0);
  endtask

  task automatic b_idle(input int n);
    for (int i = 0; i < n; i++) b_drive(0, 0, 1, 1, 36'h0, 36'h0);
  endtask

  initial begin
    #(CLK_A_PERIOD * 150000.0);
    n_run++; n_fail++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    #20;
    chk("R1", "mail1_full_n in reset", {35'b0, mail1_full_n}, 36'h1);
    chk("R1", "mail2_full_n in reset", {35'b0, mail2_full_n}, 36'h1);
    chk("R1", "a_rdata in reset", a_rdata, 36'h0);
    chk("R1", "b_rdata in reset", b_rdata, 36'h0);
    #13.5 rst_n = 1'b1;
    a_idle(3);

    // R2: post A-to-B
    cur_req = "R2";
    a_drive(1, 1, 1, 1, 36'hA_1234_5678, 36'h0);
    a_idle(1);
    #2 chk("R2", "flag after post", {35'b0, mail1_full_n}, 36'h0);
    a_idle(4);

    // R3: blocked post
    cur_req = "R3";
    a_drive(1, 1, 1, 1, 36'h5_DEAD_BEEF, 36'h0);
    a_idle(4);
    b_idle(1);
    #2 chk("R3", "word after blocked post", b_rdata, 36'hA_1234_5678);

    // R4: release, then early read after a fresh post
    cur_req = "R4";
    b_drive(1, 0, 1, 1, 36'h0, 36'h0);
    b_idle(1);
    a_idle(4);
    #2 chk("R4", "flag after release", {35'b0, mail1_full_n}, 36'h1);
    a_drive(1, 1, 1, 1, 36'h3_0000_0003, 36'h0);
    a_idle(1);
    b_drive(1, 0, 1, 1, 36'h0, 36'h0);
    b_idle(1);
    a_idle(6);
    b_drive(1, 0, 1, 1, 36'h0, 36'h0);
    b_idle(3);
    a_idle(4);

    // R5: B-to-A slot
    cur_req = "R5";
    b_drive(1, 1, 1, 1, 36'hC_CAFE_F00D, 36'h0);
    b_idle(4);
    a_drive(1, 0, 1, 1, 36'h0, 36'h0);
    a_idle(1);
    #2 chk("R5", "a_rdata shows B word", a_rdata, 36'hC_CAFE_F00D);
    b_idle(4);

    // R6: word persists after reads
    cur_req = "R6";
    a_drive(1, 0, 1, 1, 36'h0, 36'h0);
    a_drive(1, 0, 1, 1, 36'h0, 36'h0);
    a_idle(2);
    #2 chk("R6", "a_rdata after repeated reads", a_rdata, 36'hC_CAFE_F00D);

    // R7: lane masking
    cur_req = "R7";
    b_idle(1);
    b_bus_size = 2'd1;
    a_drive(1, 1, 1, 1, 36'hF_FFFF_FFFF, 36'h0);
    a_idle(2);
    b_idle(2);
    #2 chk("R7", "b_rdata 18-bit lane", b_rdata, 36'h0_0003_FFFF);
    b_drive(1, 0, 1, 1, 36'h0, 36'h0);
    b_idle(2);
    a_idle(4);
    b_bus_size = 2'd2;
    b_drive(1, 0, 1, 1, 36'h0, 36'h0);
    b_idle(4);
    a_idle(4);
    b_drive(1, 1, 1, 1, 36'hF_FFFF_FFFF, 36'h0);
    b_idle(4);
    a_idle(1);
    #2 chk("R7", "a_rdata 9-bit lane", a_rdata, 36'h0_0000_01FF);
    a_drive(1, 0, 1, 1, 36'h0, 36'h0);
    a_idle(2);
    b_idle(4);
    b_bus_size = 2'd0;

    // R8: output steering
    cur_req = "R8";
    a_drive(0, 0, 1, 0, 36'h0, 36'h1_1111_1111);
    #2 chk("R8", "a_rdata oe low", a_rdata, 36'h0);
    a_drive(0, 0, 0, 1, 36'h0, 36'h9_8765_4321);
    #2 chk("R8", "a_rdata queue word", a_rdata, 36'h9_8765_4321);
    b_drive(0, 0, 0, 1, 36'h0, 36'h7_7777_0001);
    #2 chk("R8", "b_rdata queue word", b_rdata, 36'h7_7777_0001);
    a_idle(1);
    b_idle(1);

    // R9: queue transfers leave slots alone
    cur_req = "R9";
    a_drive(1, 1, 0, 1, 36'h2_2222_2222, 36'h0);
    a_drive(1, 0, 0, 1, 36'h0, 36'h0);
    b_drive(1, 1, 0, 1, 36'h3_3333_3333, 36'h0);
    b_drive(1, 0, 0, 1, 36'h0, 36'h0);
    a_idle(4);
    b_idle(4);
    #2 chk("R9", "mail1_full_n after queue ops", {35'b0, mail1_full_n}, 36'h1);

    // Mixed traffic on both ports under every bus size (R2, R5 model compare)
    cur_req = "R2/R5";
    for (int sz = 0; sz < 3; sz++) begin
      b_bus_size = sz[1:0];
      fork
        for (int i = 0; i < 1500; i++)
          a_drive(($urandom % 8) < 5, $urandom % 2, ($urandom % 4) != 0,
                  ($urandom % 8) != 0, {$urandom, $urandom}, {$urandom, $urandom});
        for (int i = 0; i < 1000; i++)
          b_drive(($urandom % 8) < 5, $urandom % 2, ($urandom % 4) != 0,
                  ($urandom % 8) != 0, {$urandom, $urandom}, {$urandom, $urandom});
      join
      a_idle(2);
      b_idle(2);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule